// File: doc/BRIEF.md
# SPI Master Configuration and Interrupt Register Bank

This block is the software-visible register bank of a SPI master that uses the common clock-polarity/clock-phase serial format. A bus bridge drives simple one-cycle read and write strobes carrying a byte address and a 32-bit data word. The bank holds these settings:

- the control word, which covers enable, master mode, frame format, per-cause interrupt enables, clock polarity and phase, select hold, deep FIFO and soft reset;
- the frame size;
- a 32-bit transfer frame count.

It presents all of them to the serial datapath as plain configuration outputs.

The frame count is reached through two windows. Its low half is written through a field inside the control word. Its high half is written through a separate register, and that register reads back the whole count. The frame size and the frame count can only be changed while the block is disabled. Writes that arrive while the enable bit is set leave them untouched, but the rest of the control word still updates.

The datapath reports four single-cycle events: transmit done, receive ready, receive overflow and transmit underrun. Each event sets a sticky raw cause. Software clears a cause by writing 1 to it. The masked view gates each cause with its enable bit, and one interrupt line is the OR of the masked causes.

Top module: `spi_cfg_regbank`

## Requirements
- R1: After reset every register reads 0, except the frame size, which reads 8. All configuration outputs are 0 and `irq` is low.
- R2: Control (offset 0x00) stores these bits and drives the matching outputs: bit 0 enable, bit 1 master, bits 3:2 format, bits 7:4 interrupt enables, bit 24 clock polarity, bit 25 clock phase, bit 26 select hold, bit 29 deep FIFO and bit 31 soft reset. Bits 27, 28 and 30 read 0.
- R3: A control write loads bits 23:8 into the low 16 bits of the frame count only if the enable bit was 0 before that write. Control bits 23:8 always read back the low half of the count.
- R4: A write to the upper count register (0x50) loads wdata[31:16] into count bits 31:16, and only while disabled. Its bits 15:0 are never written. A read of it returns the full 32-bit count.
- R5: The frame size (0x04, bits 5:0) is written only while disabled.
- R6: Each event input sets a sticky raw cause. The cause bits are: bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow, bit 3 transmit underrun. Raw status reads at 0x24 and is mirrored in bits 3:0 of status (0x08).
- R7: Writing 1 to a bit of the clear register (0x0C) clears that cause. An event on the same bit in the same cycle wins over the clear. The clear register reads 0.
- R8: Masked status (0x20) is raw ANDed with the enables. Cause 0 is gated by control bit 5, cause 1 by bit 4, cause 2 by bit 6 and cause 3 by bit 7.
- R9: `irq` is high exactly when some masked cause is set.
- R10: Any address other than the seven listed (exact byte match) reads 0, and writes to it change nothing.
- R11: `rdata` carries the addressed value in the cycle after `rd_en` and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| ev_tx_done | input | 1 | Transmit-done event pulse |
| ev_rx_ready | input | 1 | Receive-ready event pulse |
| ev_rx_overflow | input | 1 | Receive-overflow event pulse |
| ev_tx_underrun | input | 1 | Transmit-underrun event pulse |
| cfg_enable | output | 1 | Block enable |
| cfg_master | output | 1 | Master mode select |
| cfg_format | output | 2 | Frame format, 0 = polarity/phase format |
| cfg_cpol | output | 1 | Clock polarity |
| cfg_cpha | output | 1 | Clock phase |
| cfg_hold_sel | output | 1 | Keep select asserted across empty-FIFO gaps |
| cfg_deep_fifo | output | 1 | Use the 32-frame FIFO depth |
| cfg_soft_rst | output | 1 | Soft reset request |
| cfg_frame_size | output | 6 | Bits per frame |
| cfg_frame_count | output | 32 | Frames in the transfer |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt path is swept over all 16 enable patterns against all 16 raw cause patterns. This separates a wrong enable-to-cause pairing from a wrong AND or OR. Every word-aligned and unaligned address outside the map is written with all ones and read back, and the live registers are then re-read. This catches decode aliasing. The count windows are exercised with the enable bit low, then high, then dropped in the same write that carries new count bits. This tells a lock taken from the old enable value apart from one taken from the written value. Single-cause sequences check stickiness and partial clears, and a same-cycle event plus clear checks which side wins.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int DATA_W  = 32;
    localparam int HALF_W  = 16;
    localparam int CNT_W   = 2 * HALF_W;
    localparam int NCAUSE  = 4;

    // register offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_FSIZE  = 'h04;
    localparam int OFS_STAT   = 'h08;
    localparam int OFS_ICLR   = 'h0C;
    localparam int OFS_MIS    = 'h20;
    localparam int OFS_RIS    = 'h24;
    localparam int OFS_FCNTHI = 'h50;

    // control word bit positions
    localparam int BIT_EN   = 0;
    localparam int BIT_MST  = 1;
    localparam int FMT_LSB  = 2;
    localparam int IE_LSB   = 4;
    localparam int CNT_LSB  = 8;
    localparam int BIT_CPOL = 24;
    localparam int BIT_CPHA = 25;
    localparam int BIT_HOLD = 26;
    localparam int BIT_DEEP = 29;
    localparam int BIT_SRST = 31;

    // interrupt enable index within control bits 7:4
    localparam int IE_RXDATA = 0;
    localparam int IE_TXDATA = 1;
    localparam int IE_RXOVF  = 2;
    localparam int IE_TXUND  = 3;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CTRL, SEL_FSIZE, SEL_STAT,
        SEL_ICLR, SEL_MIS, SEL_RIS, SEL_FCNTHI
    } reg_sel_e;

    typedef struct packed {
        logic              soft_rst;
        logic              deep_fifo;
        logic              hold_sel;
        logic              cpha;
        logic              cpol;
        logic [NCAUSE-1:0] ie;
        logic [1:0]        format;
        logic              master;
        logic              enable;
    } ctrl_fields_t;

endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        sel = SEL_NONE;
        if (addr == ADDR_W'(OFS_CTRL))        sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_FSIZE))  sel = SEL_FSIZE;
        else if (addr == ADDR_W'(OFS_STAT))   sel = SEL_STAT;
        else if (addr == ADDR_W'(OFS_ICLR))   sel = SEL_ICLR;
        else if (addr == ADDR_W'(OFS_MIS))    sel = SEL_MIS;
        else if (addr == ADDR_W'(OFS_RIS))    sel = SEL_RIS;
        else if (addr == ADDR_W'(OFS_FCNTHI)) sel = SEL_FCNTHI;
    end

endmodule

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
    import spi_cfg_pkg::*;
#(
    parameter int FS_W     = 6,
    parameter int FS_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_fsize,
    input  logic              wr_fhi,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_fields_t      ctrl,
    output logic [FS_W-1:0]   fsize,
    output logic [CNT_W-1:0]  fcount
);

    typedef struct packed {
        ctrl_fields_t     ctrl;
        logic [FS_W-1:0]  fsize;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[27], wdata[28], wdata[30]};

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.enable    = wdata[BIT_EN];
            st_d.ctrl.master    = wdata[BIT_MST];
            st_d.ctrl.format    = wdata[FMT_LSB +: 2];
            st_d.ctrl.ie        = wdata[IE_LSB +: NCAUSE];
            st_d.ctrl.cpol      = wdata[BIT_CPOL];
            st_d.ctrl.cpha      = wdata[BIT_CPHA];
            st_d.ctrl.hold_sel  = wdata[BIT_HOLD];
            st_d.ctrl.deep_fifo = wdata[BIT_DEEP];
            st_d.ctrl.soft_rst  = wdata[BIT_SRST];
            // lock is taken from the enable held before this write (R3)
            if (!st_q.ctrl.enable)
                st_d.cnt[HALF_W-1:0] = wdata[CNT_LSB +: HALF_W];
        end
        if (wr_fsize && !st_q.ctrl.enable)
            st_d.fsize = wdata[FS_W-1:0];
        if (wr_fhi && !st_q.ctrl.enable)
            st_d.cnt[CNT_W-1:HALF_W] = wdata[DATA_W-1:DATA_W-HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fsize <= FS_W'(FS_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign fsize  = st_q.fsize;
    assign fcount = st_q.cnt;

    // R3/R4: count cannot move while enabled
    p_count_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.enable |=> $stable(st_q.cnt))
        else $error("count changed while enabled");

    // R5: frame size cannot move while enabled
    p_fsize_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.enable |=> $stable(st_q.fsize))
        else $error("frame size changed while enabled");

    // R4: upper-register write never touches the low half
    p_hi_low_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fhi && !wr_ctrl) |=> $stable(st_q.cnt[HALF_W-1:0]))
        else $error("upper write altered low count");

endmodule

// File: rtl/spi_cfg_irq.sv
module spi_cfg_irq
    import spi_cfg_pkg::*;
#(
    parameter int NC = NCAUSE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] ev,
    input  logic          clr_we,
    input  logic [NC-1:0] clr_bits,
    input  logic [NC-1:0] en,
    output logic [NC-1:0] raw,
    output logic [NC-1:0] masked,
    output logic          irq
);

    logic [NC-1:0] raw_d, raw_q;

    always_comb begin
        raw_d = raw_q;
        if (clr_we)
            raw_d = raw_d & ~clr_bits;
        raw_d = raw_d | ev;   // set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    for (genvar i = 0; i < NC; i++) begin : g_mask
        assign masked[i] = raw_q[i] & en[i];
    end

    assign raw = raw_q;
    assign irq = |masked;

    // R7: an event always lands, even against a clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((raw_q & $past(ev)) == $past(ev)))
        else $error("event lost");

    // R7: cleared bits drop when no event competes
    p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((clr_bits & ev) == '0)) |=> ((raw_q & $past(clr_bits)) == '0))
        else $error("clear ignored");

    // R6: causes are sticky without a clear
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((raw_q & $past(raw_q)) == $past(raw_q)))
        else $error("cause dropped without clear");

    // R9: no raw cause means no interrupt
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q == '0) |-> !irq)
        else $error("irq without cause");

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int FS_W     = 6,
    parameter int FS_RESET = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ev_tx_done,
    input  logic              ev_rx_ready,
    input  logic              ev_rx_overflow,
    input  logic              ev_tx_underrun,
    output logic              cfg_enable,
    output logic              cfg_master,
    output logic [1:0]        cfg_format,
    output logic              cfg_cpol,
    output logic              cfg_cpha,
    output logic              cfg_hold_sel,
    output logic              cfg_deep_fifo,
    output logic              cfg_soft_rst,
    output logic [FS_W-1:0]   cfg_frame_size,
    output logic [31:0]       cfg_frame_count,
    output logic              irq
);

    reg_sel_e          sel;
    ctrl_fields_t      ctrl;
    logic [FS_W-1:0]   fsize;
    logic [CNT_W-1:0]  fcount;
    logic [NCAUSE-1:0] ev, en_map, raw, masked;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    spi_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .sel  (sel)
    );

    spi_cfg_ctrl #(.FS_W(FS_W), .FS_RESET(FS_RESET)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_en && sel == SEL_CTRL),
        .wr_fsize (wr_en && sel == SEL_FSIZE),
        .wr_fhi   (wr_en && sel == SEL_FCNTHI),
        .wdata    (wdata),
        .ctrl     (ctrl),
        .fsize    (fsize),
        .fcount   (fcount)
    );

    assign ev = {ev_tx_underrun, ev_rx_overflow, ev_rx_ready, ev_tx_done};

    // cause order differs from enable order for the two data causes
    assign en_map = {ctrl.ie[IE_TXUND], ctrl.ie[IE_RXOVF],
                     ctrl.ie[IE_RXDATA], ctrl.ie[IE_TXDATA]};

    spi_cfg_irq #(.NC(NCAUSE)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_we   (wr_en && sel == SEL_ICLR),
        .clr_bits (wdata[NCAUSE-1:0]),
        .en       (en_map),
        .raw      (raw),
        .masked   (masked),
        .irq      (irq)
    );

    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CTRL:   rdata_d = {ctrl.soft_rst, 1'b0, ctrl.deep_fifo, 2'b00,
                                       ctrl.hold_sel, ctrl.cpha, ctrl.cpol,
                                       fcount[HALF_W-1:0], ctrl.ie, ctrl.format,
                                       ctrl.master, ctrl.enable};
                SEL_FSIZE:  rdata_d = DATA_W'(fsize);
                SEL_STAT:   rdata_d = DATA_W'(raw);
                SEL_MIS:    rdata_d = DATA_W'(masked);
                SEL_RIS:    rdata_d = DATA_W'(raw);
                SEL_FCNTHI: rdata_d = fcount;
                default:    rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata           = rdata_q;
    assign cfg_enable      = ctrl.enable;
    assign cfg_master      = ctrl.master;
    assign cfg_format      = ctrl.format;
    assign cfg_cpol        = ctrl.cpol;
    assign cfg_cpha        = ctrl.cpha;
    assign cfg_hold_sel    = ctrl.hold_sel;
    assign cfg_deep_fifo   = ctrl.deep_fifo;
    assign cfg_soft_rst    = ctrl.soft_rst;
    assign cfg_frame_size  = fsize;
    assign cfg_frame_count = fcount;

    // R10: unmapped reads return zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rdata == '0))
        else $error("unmapped read not zero");

    // R11: no strobe, no data
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0))
        else $error("rdata without read");

    // R7: clear register reads zero
    p_clear_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_ICLR) |=> (rdata == '0))
        else $error("clear register read not zero");

endmodule

// File: tb/spi_cfg_regbank_bench.sv
module spi_cfg_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  ev = '0;
    logic        cfg_enable, cfg_master, cfg_cpol, cfg_cpha;
    logic        cfg_hold_sel, cfg_deep_fifo, cfg_soft_rst, irq;
    logic [1:0]  cfg_format;
    logic [5:0]  cfg_frame_size;
    logic [31:0] cfg_frame_count;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    spi_cfg_regbank u_spi_cfg_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ev_tx_done(ev[0]), .ev_rx_ready(ev[1]),
        .ev_rx_overflow(ev[2]), .ev_tx_underrun(ev[3]),
        .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_format(cfg_format),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_hold_sel(cfg_hold_sel),
        .cfg_deep_fifo(cfg_deep_fifo), .cfg_soft_rst(cfg_soft_rst),
        .cfg_frame_size(cfg_frame_size), .cfg_frame_count(cfg_frame_count),
        .irq(irq)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] p);
        @(negedge clk);
        ev = p;
        @(negedge clk);
        ev = '0;
    endtask

    function automatic bit is_mapped(input int a);
        return a == 'h00 || a == 'h04 || a == 'h08 || a == 'h0C ||
               a == 'h20 || a == 'h24 || a == 'h50;
    endfunction

    function automatic logic [3:0] enmap(input logic [3:0] ie);
        return {ie[3], ie[2], ie[0], ie[1]};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd('h00, d); chk("R1 control reset", d, 32'h0);
        rd('h04, d); chk("R1 frame size reset", d, 32'd8);
        rd('h08, d); chk("R1 status reset", d, 32'h0);
        rd('h20, d); chk("R1 masked reset", d, 32'h0);
        rd('h24, d); chk("R1 raw reset", d, 32'h0);
        rd('h50, d); chk("R1 count reset", d, 32'h0);
        chk("R1 irq reset", {31'b0, irq}, 32'h0);
        chk("R1 cfg reset", {24'b0, cfg_enable, cfg_master, cfg_cpol, cfg_cpha,
            cfg_hold_sel, cfg_deep_fifo, cfg_soft_rst, 1'b0}, 32'h0);

        // R2/R3 control fields while disabled
        wr('h00, 32'hFFFF_FFFE);
        rd('h00, d); chk("R2 control readback", d, 32'hA7FF_FFFE);
        chk("R2 cfg outputs", {24'b0, cfg_enable, cfg_master, cfg_format, cfg_cpol,
            cfg_cpha, cfg_hold_sel, cfg_deep_fifo},
            {24'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1, 1'b1});
        chk("R2 soft reset out", {31'b0, cfg_soft_rst}, 32'h1);
        chk("R3 count low loaded", cfg_frame_count, 32'h0000_FFFF);

        // R4 upper half, low half ignored
        wr('h50, 32'h1234_ABCD);
        rd('h50, d); chk("R4 full count read", d, 32'h1234_FFFF);

        // R3 enabling write still loads count
        wr('h00, 32'h0056_7801);
        chk("R3 count on enabling write", cfg_frame_count, 32'h1234_5678);
        chk("R2 enable out", {31'b0, cfg_enable}, 32'h1);

        // R3 locked while enabled, other bits update
        wr('h00, 32'h0199_9903);
        rd('h00, d); chk("R3 count locked in control", d, 32'h0156_7803);
        wr('h50, 32'hFFFF_0000);
        rd('h50, d); chk("R4 upper locked", d, 32'h1234_5678);
        wr('h04, 32'h0000_0010);
        rd('h04, d); chk("R5 frame size locked", d, 32'd8);

        // R3 disabling write uses old enable: count untouched
        wr('h00, 32'h0000_0000);
        rd('h00, d); chk("R3 disabling write keeps count", d, 32'h0056_7800);
        wr('h04, 32'hFFFF_FFFF);
        rd('h04, d); chk("R5 frame size written", d, 32'h3F);
        chk("R5 frame size out", {26'b0, cfg_frame_size}, 32'h3F);

        // R10 unmapped sweep
        for (int a = 0; a < 128; a++) begin
            if (!is_mapped(a)) begin
                wr(7'(a), 32'hFFFF_FFFF);
                rd(7'(a), d);
                chk($sformatf("R10 unmapped 0x%02h", a), d, 32'h0);
            end
        end
        rd('h00, d); chk("R10 control intact", d, 32'h0056_7800);
        rd('h04, d); chk("R10 frame size intact", d, 32'h3F);
        rd('h50, d); chk("R10 count intact", d, 32'h1234_5678);
        rd('h24, d); chk("R10 raw intact", d, 32'h0);

        // R11 idle rdata
        @(negedge clk); chk("R11 idle rdata", rdata, 32'h0);

        // R6/R8/R9 sweep enables x causes
        for (int e = 0; e < 16; e++) begin
            wr('h00, 32'h0056_7800 | (e << 4));
            for (int p = 0; p < 16; p++) begin
                logic [3:0] m;
                m = 4'(p) & enmap(4'(e));
                wr('h0C, 32'hF);
                pulse(4'(p));
                rd('h24, d); chk($sformatf("R6 raw e=%0d p=%0d", e, p), d, 32'(p));
                rd('h08, d); chk("R6 status mirror", d, 32'(p));
                rd('h20, d); chk($sformatf("R8 masked e=%0d p=%0d", e, p), d, 32'(m));
                chk("R9 irq", {31'b0, irq}, {31'b0, |m});
            end
        end

        // R6 sticky and R7 partial clear
        wr('h00, 32'h0000_00F0);
        wr('h0C, 32'hF);
        pulse(4'b0001);
        pulse(4'b0100);
        rd('h24, d); chk("R6 sticky accumulate", d, 32'h5);
        wr('h0C, 32'h1);
        rd('h24, d); chk("R7 partial clear", d, 32'h4);
        chk("R9 irq still high", {31'b0, irq}, 32'h1);
        rd('h0C, d); chk("R7 clear reads zero", d, 32'h0);

        // R7 set wins over same-cycle clear
        @(negedge clk);
        wr_en = 1'b1; addr = 'h0C; wdata = 32'hF; ev = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; ev = '0;
        rd('h24, d); chk("R7 set wins", d, 32'h2);
        wr('h0C, 32'hF);
        rd('h24, d); chk("R7 full clear", d, 32'h0);
        chk("R9 irq low", {31'b0, irq}, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule